// File: doc/BRIEF.md
# Next Program Counter Selector

This block decides where instruction fetch goes next in a 32-bit load/store processor with a five-stage pipeline. It is purely combinational. It takes the current program counter, the decoded branch and jump strobes, the ALU equality flag, the sign-extended branch displacement, the 26-bit jump index and a register operand. From these it produces the next fetch address, a strobe that marks a non-sequential load of the PC, and the return address for the link-writing jumps.

Four paths compete for the next address. The sequential address is PC + 4. A conditional branch adds the displacement, in words, to PC + 4. A direct jump keeps the top four bits of the current PC and fills the rest from the jump index, ending in two zero bits. A register jump uses the register operand as it is. The paths are ranked in a fixed order, and the link write-back is enabled only for jumps.

Top module: `npc_unit`

## Requirements
- R1: With no branch or jump strobe active, `nextPc` equals `pc + 4` and `pcLoad` is 0.
- R2: When `isBeq` is 1 and `zeroFlag` is 1, `nextPc` equals `pc + 4 + (brOffset << 2)` and `pcLoad` is 1.
- R3: When `isBne` is 1 and `zeroFlag` is 0, `nextPc` equals `pc + 4 + (brOffset << 2)` and `pcLoad` is 1.
- R4: An untaken branch has no effect. This covers `isBeq` with `zeroFlag` 0, and `isBne` with `zeroFlag` 1. In both cases `nextPc` is `pc + 4` and `pcLoad` is 0.
- R5: When `isJump` is 1 and `isJumpReg` is 0, `nextPc` is `{pc[31:28], jumpField[25:0], 2'b00}` and `pcLoad` is 1.
- R6: When `isJumpReg` is 1, `nextPc` equals `regValue` and `pcLoad` is 1.
- R7: The ranking is fixed. A register jump beats a direct jump, a direct jump beats a taken branch, and a taken branch beats the sequential address.
- R8: `linkAddr` always equals `pc + 4`.
- R9: `linkWe` is 1 exactly when `doLink` is 1 and `isJump` or `isJumpReg` is 1. When `doLink` is active with only a branch strobe, or with no strobe, `linkWe` stays 0.
- R10: All address sums wrap modulo 2^32, and a negative displacement moves the target backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Current program counter |
| brOffset | input | 32 | Sign-extended branch displacement in words |
| jumpField | input | 26 | Jump index from the instruction |
| regValue | input | 32 | Register operand for register jumps |
| zeroFlag | input | 1 | ALU equality flag |
| isBeq | input | 1 | Branch-if-equal strobe |
| isBne | input | 1 | Branch-if-not-equal strobe |
| isJump | input | 1 | Direct jump strobe |
| isJumpReg | input | 1 | Register jump strobe |
| doLink | input | 1 | Link request from decode |
| nextPc | output | 32 | Selected next fetch address |
| pcLoad | output | 1 | Non-sequential PC load |
| linkAddr | output | 32 | Return address for write-back |
| linkWe | output | 1 | Link register write enable |

## Verification
The bench tries each branch strobe with both values of the equality flag, which separates taken from untaken and BEQ from BNE polarity. Direct jumps use PCs with different top nibbles, so that region bits coming from the wrong source show up. Combinations of strobes show whether the ranking holds, and link requests with and without jumps show whether the link gating is correct. Positive, negative and wrapping displacements, together with a PC near the top of memory, test the shift and the modular arithmetic.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // Selection strobes passed from control to datapath
  typedef struct packed {
    logic selReg;
    logic selJump;
    logic selBranch;
    logic linkWe;
  } npcSelT;
endpackage

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
(
  input  logic   zeroFlag,
  input  logic   isBeq,
  input  logic   isBne,
  input  logic   isJump,
  input  logic   isJumpReg,
  input  logic   doLink,
  output npcSelT sel,
  output logic   pcLoad
);
  logic branchTaken;

  always_comb begin
    branchTaken   = (isBeq && zeroFlag) || (isBne && !zeroFlag);
    sel.selReg    = isJumpReg;
    sel.selJump   = isJump && !isJumpReg;
    sel.selBranch = branchTaken && !isJump && !isJumpReg;
    sel.linkWe    = doLink && (isJump || isJumpReg);
    pcLoad        = sel.selReg || sel.selJump || sel.selBranch;
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int JFIELD_W = 26,
  parameter int ALIGN_W  = 2
) (
  input  logic [ADDR_W-1:0]   pc,
  input  logic [ADDR_W-1:0]   brOffset,
  input  logic [JFIELD_W-1:0] jumpField,
  input  logic [ADDR_W-1:0]   regValue,
  input  npcSelT              sel,
  output logic [ADDR_W-1:0]   nextPc,
  output logic [ADDR_W-1:0]   linkAddr
);
  localparam int REGION_W = ADDR_W - JFIELD_W - ALIGN_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN_W);

  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] branchPc;
  logic [ADDR_W-1:0] jumpPc;

  assign seqPc    = pc + STEP;
  assign branchPc = seqPc + (brOffset << ALIGN_W);

  generate
    if (REGION_W > 0) begin : g_region
      assign jumpPc = {pc[ADDR_W-1 -: REGION_W], jumpField, {ALIGN_W{1'b0}}};
    end else begin : g_flat
      assign jumpPc = ADDR_W'({jumpField, {ALIGN_W{1'b0}}});
    end
  endgenerate

  always_comb begin
    if (sel.selReg)         nextPc = regValue;
    else if (sel.selJump)   nextPc = jumpPc;
    else if (sel.selBranch) nextPc = branchPc;
    else                    nextPc = seqPc;
  end

  assign linkAddr = seqPc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic [31:0] pc,
  input  logic [31:0] brOffset,
  input  logic [25:0] jumpField,
  input  logic [31:0] regValue,
  input  logic        zeroFlag,
  input  logic        isBeq,
  input  logic        isBne,
  input  logic        isJump,
  input  logic        isJumpReg,
  input  logic        doLink,
  output logic [31:0] nextPc,
  output logic        pcLoad,
  output logic [31:0] linkAddr,
  output logic        linkWe
);
  npcSelT sel;

  npc_control u_ctrl (
    .zeroFlag(zeroFlag), .isBeq(isBeq), .isBne(isBne), .isJump(isJump),
    .isJumpReg(isJumpReg), .doLink(doLink), .sel(sel), .pcLoad(pcLoad)
  );

  npc_datapath #(.ADDR_W(32), .JFIELD_W(26), .ALIGN_W(2)) u_dp (
    .pc(pc), .brOffset(brOffset), .jumpField(jumpField), .regValue(regValue),
    .sel(sel), .nextPc(nextPc), .linkAddr(linkAddr)
  );

  assign linkWe = sel.linkWe;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic [31:0] pc,
  input logic [31:0] brOffset,
  input logic [25:0] jumpField,
  input logic [31:0] regValue,
  input logic        zeroFlag,
  input logic        isBeq,
  input logic        isBne,
  input logic        isJump,
  input logic        isJumpReg,
  input logic        doLink,
  input logic [31:0] nextPc,
  input logic        pcLoad,
  input logic [31:0] linkAddr,
  input logic        linkWe
);
  always_comb begin
    if (!isBeq && !isBne && !isJump && !isJumpReg)
      assert_seq_path_R1: assert (nextPc == pc + 32'd4 && !pcLoad);
    if (isBeq && zeroFlag && !isJump && !isJumpReg)
      assert_beq_taken_R2: assert (pcLoad && nextPc == pc + 32'd4 + (brOffset << 2));
    if (isBne && !zeroFlag && !isJump && !isJumpReg)
      assert_bne_taken_R3: assert (pcLoad && nextPc == pc + 32'd4 + (brOffset << 2));
    if (!((isBeq && zeroFlag) || (isBne && !zeroFlag)) && !isJump && !isJumpReg)
      assert_untaken_R4: assert (!pcLoad && nextPc == linkAddr);
    if (isJump && !isJumpReg)
      assert_direct_jump_R5: assert (pcLoad && nextPc[31:28] == pc[31:28]
                                     && nextPc[27:2] == jumpField && nextPc[1:0] == 2'b00);
    if (isJumpReg)
      assert_reg_jump_R6: assert (pcLoad && nextPc == regValue);
    assert_link_addr_R8: assert (linkAddr == pc + 32'd4);
    if (!isJump && !isJumpReg)
      assert_no_link_R9: assert (!linkWe);
    if (doLink && (isJump || isJumpReg))
      assert_link_we_R9: assert (linkWe);
  end
endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] pc, brOffset, regValue;
  logic [25:0] jumpField;
  logic zeroFlag, isBeq, isBne, isJump, isJumpReg, doLink;
  logic [31:0] nextPc, linkAddr;
  logic pcLoad, linkWe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  npc_unit dut (.*);

  task automatic drive(input logic [31:0] p, input logic [31:0] off,
                       input logic [25:0] jf, input logic [31:0] rv,
                       input logic z, input logic beq, input logic bne,
                       input logic j, input logic jr, input logic lk);
    @(negedge clk);
    pc = p; brOffset = off; jumpField = jf; regValue = rv;
    zeroFlag = z; isBeq = beq; isBne = bne; isJump = j; isJumpReg = jr; doLink = lk;
    #1;
  endtask

  task automatic expectOut(input string req, input logic [31:0] expPc,
                           input logic expLoad, input logic expWe);
    nChecks++;
    if (nextPc !== expPc || pcLoad !== expLoad || linkWe !== expWe ||
        linkAddr !== pc + 32'd4) begin
      nFails++;
      $display("FAIL %s: nextPc=%h pcLoad=%b linkWe=%b linkAddr=%h expected %h %b %b %h",
               req, nextPc, pcLoad, linkWe, linkAddr, expPc, expLoad, expWe, pc + 32'd4);
    end
  endtask

  task automatic testSequential();
    drive(32'h0040_0000, 32'h10, 26'h0, 32'h0, 1'b0, 0, 0, 0, 0, 0);
    expectOut("R1", 32'h0040_0004, 0, 0);
    drive(32'h1234_5678, 32'h0, 26'h0, 32'h0, 1'b1, 0, 0, 0, 0, 0);
    expectOut("R1", 32'h1234_567C, 0, 0);
  endtask

  task automatic testBeq();
    drive(32'h0040_0100, 32'h0000_0003, 26'h0, 32'h0, 1'b1, 1, 0, 0, 0, 0);
    expectOut("R2", 32'h0040_0110, 1, 0);
    drive(32'h0040_0100, 32'h0000_0003, 26'h0, 32'h0, 1'b0, 1, 0, 0, 0, 0);
    expectOut("R4 beq untaken", 32'h0040_0104, 0, 0);
  endtask

  task automatic testBne();
    drive(32'h0040_0200, 32'h0000_0010, 26'h0, 32'h0, 1'b0, 0, 1, 0, 0, 0);
    expectOut("R3", 32'h0040_0244, 1, 0);
    drive(32'h0040_0200, 32'h0000_0010, 26'h0, 32'h0, 1'b1, 0, 1, 0, 0, 0);
    expectOut("R4 bne untaken", 32'h0040_0204, 0, 0);
  endtask

  task automatic testOffsets();
    drive(32'h0040_0100, 32'hFFFF_FFFC, 26'h0, 32'h0, 1'b1, 1, 0, 0, 0, 0);
    expectOut("R10 negative", 32'h0040_00F4, 1, 0);
    drive(32'hFFFF_FFFC, 32'h0000_0000, 26'h0, 32'h0, 1'b0, 0, 0, 0, 0, 0);
    expectOut("R10 wrap seq", 32'h0000_0000, 0, 0);
    drive(32'hFFFF_FFF0, 32'h0000_0008, 26'h0, 32'h0, 1'b0, 0, 1, 0, 0, 0);
    expectOut("R10 wrap branch", 32'h0000_0014, 1, 0);
  endtask

  task automatic testJump();
    drive(32'hA000_0000, 32'h0, 26'h3FF_FFFF, 32'h0, 1'b0, 0, 0, 1, 0, 0);
    expectOut("R5", 32'hAFFF_FFFC, 1, 0);
    drive(32'h5123_4560, 32'h0, 26'h012_3456, 32'h0, 1'b0, 0, 0, 1, 0, 0);
    expectOut("R5", 32'h5048_D158, 1, 0);
  endtask

  task automatic testJumpReg();
    drive(32'h0040_0000, 32'h0, 26'h0, 32'hDEAD_BEEF, 1'b0, 0, 0, 0, 1, 0);
    expectOut("R6", 32'hDEAD_BEEF, 1, 0);
  endtask

  task automatic testPriority();
    drive(32'h3000_0000, 32'h4, 26'h000_0010, 32'h0000_8000, 1'b1, 1, 0, 1, 1, 0);
    expectOut("R7 reg over jump", 32'h0000_8000, 1, 0);
    drive(32'h3000_0000, 32'h4, 26'h000_0010, 32'h0000_8000, 1'b1, 1, 0, 1, 0, 0);
    expectOut("R7 jump over branch", 32'h3000_0040, 1, 0);
  endtask

  task automatic testLink();
    drive(32'h0040_0010, 32'h0, 26'h000_0100, 32'h0, 1'b0, 0, 0, 1, 0, 1);
    expectOut("R9 jal", 32'h0000_0400, 1, 1);
    drive(32'h0040_0010, 32'h0, 26'h0, 32'h0050_0000, 1'b0, 0, 0, 0, 1, 1);
    expectOut("R9 jalr", 32'h0050_0000, 1, 1);
    drive(32'h0040_0010, 32'h2, 26'h0, 32'h0, 1'b1, 1, 0, 0, 0, 1);
    expectOut("R9 link with branch ignored", 32'h0040_001C, 1, 0);
    drive(32'h0040_0010, 32'h0, 26'h0, 32'h0, 1'b0, 0, 0, 0, 0, 1);
    expectOut("R9 R8 link alone", 32'h0040_0014, 0, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    drive(32'h0, 32'h0, 26'h0, 32'h0, 1'b0, 0, 0, 0, 0, 0);
    expectOut("R1 idle", 32'h0000_0004, 0, 0);
    testSequential();
    testBeq();
    testBne();
    testOffsets();
    testJump();
    testJumpReg();
    testPriority();
    testLink();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule